// File: doc/BRIEF.md
# Reloadable Watchdog Timer with Reset-Cause Flags

This block is a 16-bit watchdog counter that counts up from zero after every reset. Its tick comes from a free-running prescaler. The tick rate is either half the clock rate or 1/128 of the clock rate. Software must issue a service strobe before the counter passes its maximum value. A service clears the low byte of the counter and loads the high byte from an 8-bit reload field. This lets firmware choose a shorter or longer time-out. If the count overflows, the block raises an internal reset request. It raises that request only once the bus-cycle-done input allows it. Through a control/status word it reports which kind of reset last happened: hardware, software-command or watchdog.

After any reset the disable command is accepted for a limited time. That window closes at the first service or end-of-initialization strobe. A hardware reset taken while the boot-mode input is high starts the watchdog already disabled. The reset-out indication goes low on every reset and returns high on the end-of-initialization strobe.

Status word layout: bits 15:8 hold the reload field. Bit 0 selects the slow rate. Bit 1 is the watchdog-reset flag. Bit 2 is the software-reset flag. Bit 3 is the short hardware-reset flag and bit 4 is the long hardware-reset flag. Bits 7:5 always read 0.

Top module: `reload_watchdog`

## Requirements
- R1: While `hwRstN` is low, and after it is released, `wdtCount` reads 0x0000, `ctrlStatus` reads 0x001C, `rstOutN` is 0 and `wdtRstReq` is 0.
- R2: With bit 0 of the status word clear, the counter advances on every second clock edge. Counting edges from the last reset as 1, 2, 3…, it advances on the even-numbered edges.
- R3: With bit 0 set, the counter advances only on the edges whose number (counted from the last reset) is a multiple of 128.
- R4: A service strobe sets `wdtCount` to reload×256 at that edge. Counting then continues from that value. Servicing does not restart the prescaler.
- R5: A service strobe clears status bit 1 (the watchdog-reset flag).
- R6: A disable strobe given before any service or end-of-initialization strobe since the last reset stops the counter. The counter holds its value.
- R7: After a service or end-of-initialization strobe, disable strobes have no effect, and the counter keeps advancing.
- R8: On the first tick after `wdtCount` = 0xFFFF, the count wraps to 0 and an overflow is pending. `wdtRstReq` is 1 only while the overflow is pending and `busDone` is 1. The edge after that reloads status to 0x0006, sets `wdtCount` to 0 and drives `rstOutN` low.
- R9: A software-reset strobe sets status to 0x0004 and `wdtCount` to 0. It drives `rstOutN` low, re-enables counting, reopens the disable window and restarts the prescaler.
- R10: An end-of-initialization strobe clears status bits 4:1 and drives `rstOutN` high.
- R11: A hardware reset taken with `bootMode` = 1 leaves the counter disabled at 0.
- R12: If a service strobe coincides with the overflow tick, the service wins. The count becomes reload×256 and no reset request follows.
- R13: `idleIn` has no effect on counting.
- R14: A control write (`ctrlWr`) loads the reload field into status bits 15:8 and the rate select into bit 0. The flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hwRstN | input | 1 | Asynchronous active-low hardware reset |
| bootMode | input | 1 | Boot mode; sampled during hardware reset, starts the watchdog disabled |
| disableCmd | input | 1 | Disable command strobe |
| serviceCmd | input | 1 | Service command strobe |
| endInitCmd | input | 1 | End-of-initialization command strobe |
| softResetCmd | input | 1 | Software-reset command strobe |
| idleIn | input | 1 | Idle indication (counting continues) |
| busDone | input | 1 | External bus cycle finished or aborted; releases a pending overflow |
| ctrlWr | input | 1 | Control write strobe |
| ctrlWrReload | input | 8 | Reload value written by `ctrlWr` |
| ctrlWrSlow | input | 1 | Rate select written by `ctrlWr` (1 = clock/128) |
| wdtRstReq | output | 1 | Internal reset request |
| rstOutN | output | 1 | Reset-out indication, active low |
| wdtCount | output | 16 | Current counter value |
| ctrlStatus | output | 16 | Control/status word |

## Verification
The service-and-count path is swept over all 256 reload values at the fast rate. Each sweep step checks the loaded value and a few edges of counting after it, which separates a wrong reload byte position from a wrong tick phase. The slow rate is checked across several 128-edge boundaries, and the idle input is toggled during counting. Overflow is driven from a reload of 0xFF with the bus handshake first held off and then released. A service is placed exactly on the overflow tick to show that the service wins. Disable strobes are given inside and outside the window, and hardware, software and watchdog resets are each followed by a read of the status word to confirm the reset cause it reports.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
    logic inc;
  } cntCtl_t;

  // status word bit positions
  localparam int SEL_BIT = 0;
  localparam int WDR_BIT = 1;
  localparam int SWR_BIT = 2;
  localparam int SHW_BIT = 3;
  localparam int LHW_BIT = 4;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 7
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic slowSel,
  output logic tick
);
  logic [PRE_W-1:0] preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      preCnt <= '0;
    else if (clear) preCnt <= '0;
    else            preCnt <= preCnt + 1'b1;
  end

  // fast: every second edge; slow: once per full prescaler wrap
  assign tick = slowSel ? (&preCnt) : preCnt[0];
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RELOAD_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  cntCtl_t             ctl,
  input  logic [RELOAD_W-1:0] reloadVal,
  output logic [CNT_W-1:0]    count,
  output logic                atMax
);
  localparam int LOW_W = CNT_W - RELOAD_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         count <= '0;
    else if (ctl.clear) count <= '0;
    else if (ctl.load)  count <= {reloadVal, {LOW_W{1'b0}}};
    else if (ctl.inc)   count <= count + 1'b1;
  end

  assign atMax = &count;
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
#(
  parameter int RELOAD_W = 8,
  localparam int STAT_W  = RELOAD_W + 8
) (
  input  logic                clk,
  input  logic                hwRstN,
  input  logic                bootMode,
  input  logic                disableCmd,
  input  logic                serviceCmd,
  input  logic                endInitCmd,
  input  logic                softResetCmd,
  input  logic                busDone,
  input  logic                ctrlWr,
  input  logic [RELOAD_W-1:0] ctrlWrReload,
  input  logic                ctrlWrSlow,
  input  logic                tick,
  input  logic                atMax,
  output cntCtl_t             cntCtl,
  output logic                preClear,
  output logic                wdtRstReq,
  output logic                rstOutN,
  output logic [STAT_W-1:0]   status
);
  localparam logic [STAT_W-1:0] HW_VAL  = STAT_W'(5'b11100);
  localparam logic [STAT_W-1:0] SW_VAL  = STAT_W'(5'b00100);
  localparam logic [STAT_W-1:0] WDR_VAL = STAT_W'(5'b00110);

  logic enabled, windowOpen, pending;
  logic wdRstNow, intRst, ovf, closeWin;
  logic [STAT_W-1:0] statusNxt;

  assign wdRstNow = pending & busDone;
  assign intRst   = wdRstNow | softResetCmd;
  assign closeWin = serviceCmd | endInitCmd;
  assign ovf      = enabled & tick & atMax & ~pending & ~serviceCmd & ~intRst;

  assign cntCtl.clear = intRst;
  assign cntCtl.load  = serviceCmd & ~intRst;
  assign cntCtl.inc   = enabled & tick & ~pending & ~serviceCmd & ~intRst;
  assign preClear     = intRst;
  assign wdtRstReq    = wdRstNow;

  always_comb begin
    statusNxt = status;
    if (ctrlWr) begin
      statusNxt[STAT_W-1 -: RELOAD_W] = ctrlWrReload;
      statusNxt[SEL_BIT]              = ctrlWrSlow;
    end
    if (serviceCmd) statusNxt[WDR_BIT] = 1'b0;
    if (endInitCmd) statusNxt[LHW_BIT:WDR_BIT] = '0;
  end

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      enabled    <= ~bootMode;
      windowOpen <= 1'b1;
      pending    <= 1'b0;
      rstOutN    <= 1'b0;
      status     <= HW_VAL;
    end else if (intRst) begin
      enabled    <= 1'b1;
      windowOpen <= 1'b1;
      pending    <= 1'b0;
      rstOutN    <= 1'b0;
      status     <= wdRstNow ? WDR_VAL : SW_VAL;
    end else begin
      status <= statusNxt;
      if (closeWin) windowOpen <= 1'b0;
      if (disableCmd && windowOpen && !closeWin) enabled <= 1'b0;
      if (endInitCmd) rstOutN <= 1'b1;
      if (ovf) pending <= 1'b1;
    end
  end
endmodule

// File: rtl/reload_watchdog.sv
module reload_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RELOAD_W = 8,
  parameter int PRE_W    = 7,
  localparam int STAT_W  = RELOAD_W + 8
) (
  input  logic                clk,
  input  logic                hwRstN,
  input  logic                bootMode,
  input  logic                disableCmd,
  input  logic                serviceCmd,
  input  logic                endInitCmd,
  input  logic                softResetCmd,
  input  logic                idleIn,
  input  logic                busDone,
  input  logic                ctrlWr,
  input  logic [RELOAD_W-1:0] ctrlWrReload,
  input  logic                ctrlWrSlow,
  output logic                wdtRstReq,
  output logic                rstOutN,
  output logic [CNT_W-1:0]    wdtCount,
  output logic [STAT_W-1:0]   ctrlStatus
);
  cntCtl_t cntCtl;
  logic tick, atMax, preClear;

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rstN(hwRstN), .clear(preClear),
    .slowSel(ctrlStatus[SEL_BIT]), .tick(tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .RELOAD_W(RELOAD_W)) u_cnt (
    .clk(clk), .rstN(hwRstN), .ctl(cntCtl),
    .reloadVal(ctrlStatus[STAT_W-1 -: RELOAD_W]),
    .count(wdtCount), .atMax(atMax)
  );

  wdt_control #(.RELOAD_W(RELOAD_W)) u_ctl (
    .clk(clk), .hwRstN(hwRstN), .bootMode(bootMode),
    .disableCmd(disableCmd), .serviceCmd(serviceCmd),
    .endInitCmd(endInitCmd), .softResetCmd(softResetCmd),
    .busDone(busDone), .ctrlWr(ctrlWr), .ctrlWrReload(ctrlWrReload),
    .ctrlWrSlow(ctrlWrSlow), .tick(tick), .atMax(atMax),
    .cntCtl(cntCtl), .preClear(preClear), .wdtRstReq(wdtRstReq),
    .rstOutN(rstOutN), .status(ctrlStatus)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W  = 16,
  parameter int STAT_W = 16
) (
  input logic              clk,
  input logic              hwRstN,
  input logic              serviceCmd,
  input logic              endInitCmd,
  input logic              softResetCmd,
  input logic              idleIn,
  input logic              busDone,
  input logic              wdtRstReq,
  input logic              rstOutN,
  input logic [CNT_W-1:0]  wdtCount,
  input logic [STAT_W-1:0] ctrlStatus
);
  localparam int LOW_W = CNT_W - (STAT_W - 8);

  // R8
  req_needs_bus_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    wdtRstReq |-> busDone);

  // R8
  wdt_reset_effect_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    wdtRstReq |=> (ctrlStatus == STAT_W'(6) && wdtCount == '0 && !rstOutN));

  // R4
  service_load_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (serviceCmd && !softResetCmd && !wdtRstReq) |=>
      wdtCount == {$past(ctrlStatus[STAT_W-1:8]), {LOW_W{1'b0}}});

  // R9
  soft_reset_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (softResetCmd && !wdtRstReq) |=> (ctrlStatus == STAT_W'(4) && wdtCount == '0 && !rstOutN));

  // R10
  end_init_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (endInitCmd && !softResetCmd && !wdtRstReq) |=> (rstOutN && ctrlStatus[4:1] == 4'b0));

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (!serviceCmd && !softResetCmd && !wdtRstReq) |=>
      (wdtCount == $past(wdtCount) || wdtCount == CNT_W'($past(wdtCount) + 1'b1)));

  // R13
  idle_step_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (idleIn && !serviceCmd && !softResetCmd && !wdtRstReq) |=>
      (wdtCount == $past(wdtCount) || wdtCount == CNT_W'($past(wdtCount) + 1'b1)));
endmodule

bind reload_watchdog wdt_checker #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .hwRstN(hwRstN), .serviceCmd(serviceCmd), .endInitCmd(endInitCmd),
  .softResetCmd(softResetCmd), .idleIn(idleIn), .busDone(busDone),
  .wdtRstReq(wdtRstReq), .rstOutN(rstOutN), .wdtCount(wdtCount),
  .ctrlStatus(ctrlStatus)
);

// File: tb/reload_watchdog_test.sv
`timescale 1ns/1ps
module reload_watchdog_test;
  logic clk = 1'b0;
  logic hwRstN = 1'b0, bootMode = 1'b0, disableCmd = 1'b0, serviceCmd = 1'b0;
  logic endInitCmd = 1'b0, softResetCmd = 1'b0, idleIn = 1'b0, busDone = 1'b0;
  logic ctrlWr = 1'b0, ctrlWrSlow = 1'b0;
  logic [7:0] ctrlWrReload = 8'h00;
  logic wdtRstReq, rstOutN;
  logic [15:0] wdtCount, ctrlStatus;

  int total = 0, bad = 0, edgeCnt = 0, base = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!hwRstN) edgeCnt = 0;
    else edgeCnt = edgeCnt + 1;
  end

  reload_watchdog uut (
    .clk(clk), .hwRstN(hwRstN), .bootMode(bootMode), .disableCmd(disableCmd),
    .serviceCmd(serviceCmd), .endInitCmd(endInitCmd), .softResetCmd(softResetCmd),
    .idleIn(idleIn), .busDone(busDone), .ctrlWr(ctrlWr), .ctrlWrReload(ctrlWrReload),
    .ctrlWrSlow(ctrlWrSlow), .wdtRstReq(wdtRstReq), .rstOutN(rstOutN),
    .wdtCount(wdtCount), .ctrlStatus(ctrlStatus)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic stepTo(input int target);
    while (edgeCnt < target) step();
  endtask

  function automatic int fastTicks(input int a, input int b);
    return (b - base) / 2 - (a - base) / 2;
  endfunction

  function automatic int slowTicks(input int a, input int b);
    return (b - base) / 128 - (a - base) / 128;
  endfunction

  task automatic hwReset(input logic boot);
    @(negedge clk);
    hwRstN = 1'b0; bootMode = boot;
    #1;
    check("R1 reset count", wdtCount, 0);
    check("R1 reset status", ctrlStatus, 16'h001C);
    step(); step();
    hwRstN = 1'b1; base = 0;
  endtask

  task automatic writeCtrl(input logic [7:0] rl, input logic slow);
    ctrlWr = 1'b1; ctrlWrReload = rl; ctrlWrSlow = slow;
    step();
    ctrlWr = 1'b0;
  endtask

  task automatic service(output int s);
    serviceCmd = 1'b1; step(); serviceCmd = 1'b0; s = edgeCnt;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s, ov, v;
    @(negedge clk);
    hwReset(1'b0);
    // R1
    check("R1 status", ctrlStatus, 16'h001C);
    check("R1 rstOutN", rstOutN, 0);
    check("R1 req", wdtRstReq, 0);

    // R2 fast rate
    stepTo(37);
    check("R2 fast count", wdtCount, 37 / 2);
    // R13 idle
    idleIn = 1'b1;
    stepTo(57);
    check("R13 idle count", wdtCount, 57 / 2);
    idleIn = 1'b0;

    // R14 write
    writeCtrl(8'hA5, 1'b1);
    check("R14 status write", ctrlStatus, 16'hA51D);
    // R4 service, R3 slow rate
    service(s);
    check("R4 load", wdtCount, 16'hA500);
    stepTo(s + 300);
    check("R3 slow count", wdtCount, 16'hA500 + slowTicks(s, edgeCnt));
    // R10 end init
    endInitCmd = 1'b1; v = edgeCnt; step(); endInitCmd = 1'b0;
    check("R10 status", ctrlStatus, 16'hA501);
    check("R10 rstOutN", rstOutN, 1);
    // R7 disable ignored after window closed
    disableCmd = 1'b1; step(); disableCmd = 1'b0;
    stepTo(edgeCnt + 400);
    check("R7 keeps counting", wdtCount, 16'hA500 + slowTicks(s, edgeCnt));

    // R4 sweep over reload values, fast rate
    for (int r = 0; r < 256; r++) begin
      writeCtrl(r[7:0], 1'b0);
      service(s);
      check("R4 sweep load", wdtCount, {r[7:0], 8'h00});
      stepTo(s + (r % 7) + 1);
      check("R4 sweep count", wdtCount, {r[7:0], 8'h00} + fastTicks(s, edgeCnt));
    end
    check("R14 sweep status", ctrlStatus, 16'hFF00);

    // R9 soft reset
    softResetCmd = 1'b1; step(); softResetCmd = 1'b0; base = edgeCnt;
    check("R9 status", ctrlStatus, 16'h0004);
    check("R9 count", wdtCount, 0);
    check("R9 rstOutN", rstOutN, 0);
    stepTo(base + 9);
    check("R9 counting", wdtCount, 4);
    // R6 disable inside window
    disableCmd = 1'b1; step(); disableCmd = 1'b0;
    v = wdtCount;
    stepTo(edgeCnt + 50);
    check("R6 held", wdtCount, v);
    // R9 soft reset re-enables
    softResetCmd = 1'b1; step(); softResetCmd = 1'b0; base = edgeCnt;
    stepTo(base + 20);
    check("R9 re-enabled", wdtCount, 10);

    // R8 overflow with bus held off
    hwReset(1'b0);
    writeCtrl(8'hFF, 1'b0);
    service(s);
    ov = ((s - base) / 2 + 1) * 2 + base + 510;
    stepTo(ov - 1);
    check("R8 at max", wdtCount, 16'hFFFF);
    step();
    check("R8 wrapped", wdtCount, 0);
    check("R8 req held", wdtRstReq, 0);
    stepTo(edgeCnt + 20);
    check("R8 stalled", wdtCount, 0);
    check("R8 still held", wdtRstReq, 0);
    busDone = 1'b1; #1;
    check("R8 req", wdtRstReq, 1);
    step(); base = edgeCnt;
    check("R8 status", ctrlStatus, 16'h0006);
    check("R8 count", wdtCount, 0);
    check("R8 rstOutN", rstOutN, 0);
    check("R8 req drop", wdtRstReq, 0);
    // R5 service clears watchdog flag
    service(s);
    check("R5 flag cleared", ctrlStatus, 16'h0004);

    // R12 service coincides with overflow tick
    writeCtrl(8'hFF, 1'b0);
    service(s);
    ov = ((s - base) / 2 + 1) * 2 + base + 510;
    writeCtrl(8'h12, 1'b0);
    stepTo(ov - 1);
    check("R12 at max", wdtCount, 16'hFFFF);
    service(s);
    check("R12 service wins", wdtCount, 16'h1200);
    stepTo(edgeCnt + 10);
    check("R12 no req", wdtRstReq, 0);
    check("R12 counting", wdtCount, 16'h1200 + fastTicks(s, edgeCnt));
    busDone = 1'b0;

    // R11 boot-mode hardware reset
    hwReset(1'b1);
    bootMode = 1'b0;
    stepTo(40);
    check("R11 disabled", wdtCount, 0);
    check("R11 status", ctrlStatus, 16'h001C);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule